// File: doc/BRIEF.md
# Temperature Conversion Sequencer

This block decides when a temperature conversion runs, how long it takes and what lands in the 12-bit result register. A signed 12-bit sample arrives on an input port from an external converter model. When a conversion finishes, the block takes that sample, clears the low bits that the selected resolution does not cover, and stores the result. It also pulses a one-cycle strobe, which downstream alert logic can use to start a limit comparison.

An 8-bit configuration byte controls the block. Bit 0 is the shutdown flag. Bits 6:5 select the resolution. Bit 7 is the one-shot trigger. Bits 4:1 are plain storage that reads back as written. When shutdown is clear, conversions run back to back. When shutdown is set, the conversion in progress runs to completion and the block then goes quiet. While the block is quiet, a one-shot write runs exactly one conversion. The read view of the configuration always shows the one-shot bit as zero.

Each conversion lasts `TICKS_PER_UNIT << code` clock cycles, so every extra bit of resolution doubles the time. A conversion uses the resolution that was in force when it started.

Top module: `temp_conv_seq`

## Requirements
- R1: Under reset, `temp_word` reads 0, `conv_done` is low and `cfg_rdata` reads 0. A 9-bit conversion starts on the first clock edge after reset. `temp_word` stays 0 until that conversion completes, which is `TICKS_PER_UNIT` cycles after reset is released.
- R2: Resolution codes 00, 01, 10 and 11 in `cfg_wdata[6:5]` select 9, 10, 11 and 12 bits. A conversion at code c takes `TICKS_PER_UNIT << c` cycles.
- R3: At code c, the stored value equals the sample with its lowest `3 - c` bits forced to zero. All higher bits are kept unchanged.
- R4: At 12 bits, the two's complement sample is stored unchanged. For example, 0x190 (+25 °C) and 0xE70 (-25 °C) are stored as is.
- R5: A new resolution takes effect from the next conversion that starts. The conversion already in flight keeps its starting resolution.
- R6: While the shutdown bit (bit 0) is 0, a new conversion starts in the same cycle that the previous one completes.
- R7: Setting the shutdown bit lets the conversion in progress finish and load its result. After that, no further conversion runs and `temp_word` holds.
- R8: A one-shot write (bit 7 = 1) made while the block is shut down runs exactly one conversion at the resolution in that write. The result loads `TICKS_PER_UNIT << c` cycles after the write edge, and the block then returns to shutdown.
- R9: A one-shot write made while a conversion is running (continuous, or shutdown pending) has no effect. The running conversion is not restarted, and no extra conversion follows it.
- R10: `cfg_rdata` bit 7 always reads 0. Bits 6:0 read back the last written values.
- R11: `conv_done` is high for exactly one cycle, in the cycle when a new result first appears on `temp_word`. `temp_word` changes in no other cycle.
- R12: Clearing the shutdown bit while the block is shut down restarts continuous conversion. The first conversion starts on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: bit 7 one-shot, bits 6:5 resolution, bits 4:1 storage, bit 0 shutdown |
| adc_sample | input | 12 | Signed sample from the converter model |
| temp_word | output | 12 | Temperature result register |
| conv_done | output | 1 | One-cycle strobe when a result loads |
| cfg_rdata | output | 8 | Configuration read view, bit 7 always 0 |

## Verification
The assertions check the following on every cycle:
- the reset values;
- that the done strobe lasts a single cycle;
- that the result register changes only together with the strobe;
- that the one-shot bit reads zero and the configuration holds between writes;
- that successive strobes are never closer than the shortest conversion.

Some behaviours can only be shown by the bench's scenarios, because they depend on history and on exact cycle counts:
- the exact length of each conversion for each resolution;
- the point at which a resolution change takes effect;
- the last conversion before shutdown completing;
- one-shot runs producing exactly one result;
- one-shot writes being ignored while a conversion is running.

// File: rtl/temp_conv_pkg.sv
package temp_conv_pkg;

    localparam int TEMP_W    = 12;
    localparam int RES_CODES = 4;
    localparam int DROP_MAX  = 3;

    typedef struct packed {
        logic       one_shot;
        logic [1:0] res;
        logic [3:0] spare;
        logic       sd;
    } cfg_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } seq_state_e;

    function automatic logic [1:0] drop_count(logic [1:0] res);
        return 2'd3 - res;
    endfunction

endpackage

// File: rtl/temp_cfg_reg.sv
module temp_cfg_reg
    import temp_conv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  cfg_t       wdata,
    output cfg_t       cfg_q,
    output logic       os_req,
    output logic [1:0] os_res
);

    cfg_t stored_val;

    always_comb begin
        stored_val          = wdata;
        stored_val.one_shot = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= stored_val;
        end
    end

    assign os_req = wr & wdata.one_shot;
    assign os_res = wdata.res;

endmodule

// File: rtl/temp_seq_ctrl.sv
module temp_seq_ctrl
    import temp_conv_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sd,
    input  logic [1:0] cur_res,
    input  logic       os_req,
    input  logic [1:0] os_res,
    output logic       finish,
    output logic [1:0] res_lat
);

    localparam int MAX_TICKS = TICKS_PER_UNIT << (RES_CODES - 1);
    localparam int CNT_W     = $clog2(MAX_TICKS);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       res_q;
    logic [CNT_W-1:0] end_tab [RES_CODES];

    for (genvar g = 0; g < RES_CODES; g++) begin : g_end
        assign end_tab[g] = CNT_W'(TICKS_PER_UNIT * (1 << g) - 1);
    end

    assign finish  = (state_q == ST_CONV) && (cnt_q == end_tab[res_q]);
    assign res_lat = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
            res_q   <= 2'd0;
        end else begin
            unique case (state_q)
                ST_CONV: begin
                    if (finish) begin
                        cnt_q <= '0;
                        if (sd) begin
                            state_q <= ST_IDLE;
                        end else begin
                            res_q <= cur_res;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (os_req) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                        res_q   <= os_res;
                    end else if (!sd) begin
                        state_q <= ST_CONV;
                        cnt_q   <= '0;
                        res_q   <= cur_res;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/temp_result_reg.sv
module temp_result_reg
    import temp_conv_pkg::*;
#(
    parameter int WIDTH = TEMP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             finish,
    input  logic [1:0]       res_lat,
    input  logic [WIDTH-1:0] sample,
    output logic [WIDTH-1:0] temp_q,
    output logic             done_q
);

    logic [1:0]       drop;
    logic [WIDTH-1:0] keep;
    logic [WIDTH-1:0] masked;

    assign drop = drop_count(res_lat);

    for (genvar i = 0; i < WIDTH; i++) begin : g_keep
        if (i < DROP_MAX) begin : g_low
            assign keep[i] = (2'(i) >= drop);
        end else begin : g_high
            assign keep[i] = 1'b1;
        end
    end

    assign masked = sample & keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                temp_q <= masked;
            end
        end
    end

endmodule

// File: rtl/temp_conv_seq.sv
module temp_conv_seq
    import temp_conv_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 8,
    parameter int SAMPLE_W       = TEMP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [7:0]          cfg_wdata,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic [SAMPLE_W-1:0] temp_word,
    output logic                conv_done,
    output logic [7:0]          cfg_rdata
);

    cfg_t       wcfg;
    cfg_t       cfg_q;
    logic       os_req;
    logic [1:0] os_res;
    logic       finish;
    logic [1:0] res_lat;

    assign wcfg = cfg_wdata;

    temp_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (wcfg),
        .cfg_q  (cfg_q),
        .os_req (os_req),
        .os_res (os_res)
    );

    temp_seq_ctrl #(
        .TICKS_PER_UNIT (TICKS_PER_UNIT)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .sd      (cfg_q.sd),
        .cur_res (cfg_q.res),
        .os_req  (os_req),
        .os_res  (os_res),
        .finish  (finish),
        .res_lat (res_lat)
    );

    temp_result_reg #(
        .WIDTH (SAMPLE_W)
    ) u_res (
        .clk     (clk),
        .rst     (rst),
        .finish  (finish),
        .res_lat (res_lat),
        .sample  (adc_sample),
        .temp_q  (temp_word),
        .done_q  (conv_done)
    );

    assign cfg_rdata = cfg_q;

endmodule

// File: rtl/temp_conv_seq_chk.sv
module temp_conv_seq_chk #(
    parameter int TICKS_PER_UNIT = 8,
    parameter int SAMPLE_W       = 12
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_wr,
    input logic [SAMPLE_W-1:0] temp_word,
    input logic                conv_done,
    input logic [7:0]          cfg_rdata
);

    logic        live_q;
    logic        had_q;
    logic [15:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            had_q  <= 1'b0;
            gap_q  <= '0;
        end else begin
            live_q <= 1'b1;
            if (conv_done) begin
                had_q <= 1'b1;
                gap_q <= '0;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (temp_word == '0 && !conv_done && cfg_rdata == 8'h00)); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> !conv_done); // R11

    AST_TEMP_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (live_q && !conv_done) |-> $stable(temp_word)); // R11

    AST_OS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_rdata[7]); // R10

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (live_q && !cfg_wr) |=> $stable(cfg_rdata)); // R10

    AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst)
        (conv_done && had_q) |-> (gap_q >= 16'(TICKS_PER_UNIT - 1))); // R2

endmodule

bind temp_conv_seq temp_conv_seq_chk #(
    .TICKS_PER_UNIT (TICKS_PER_UNIT),
    .SAMPLE_W       (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .temp_word (temp_word),
    .conv_done (conv_done),
    .cfg_rdata (cfg_rdata)
);

// File: tb/temp_conv_seq_tb.sv
`timescale 1ns/1ps
module temp_conv_seq_tb;

    localparam int TPU = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [11:0] adc_sample = 12'h000;
    logic [11:0] temp_word;
    logic        conv_done;
    logic [7:0]  cfg_rdata;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    temp_conv_seq #(.TICKS_PER_UNIT(TPU)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .adc_sample (adc_sample),
        .temp_word  (temp_word),
        .conv_done  (conv_done),
        .cfg_rdata  (cfg_rdata)
    );

    function automatic int dur(int r);
        return TPU << r;
    endfunction

    function automatic logic [11:0] exp_val(logic [11:0] s, int r);
        logic [11:0] m;
        m = 12'hFFF << (3 - r);
        return s & m;
    endfunction

    function automatic logic [7:0] mk(bit os, int r, bit sd);
        return {os, 2'(r), 4'b0000, sd};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!conv_done && n < 2000);
    endtask

    task automatic quiet(int cyc, output int hits);
        hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (conv_done) hits++;
        end
    endtask

    task automatic write_cfg(logic [7:0] v);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n, hits, cur, r;
        logic [11:0] s, held;
        void'($urandom(32'h1234_5EED));
        adc_sample = 12'h19D;
        repeat (4) @(negedge clk);
        check(temp_word == 12'h000, "R1 reset temp", temp_word, 0);
        check(!conv_done, "R1 reset done", conv_done, 0);
        check(cfg_rdata == 8'h00, "R1 reset cfg", cfg_rdata, 0);
        rst = 1'b0;
        repeat (TPU - 1) @(negedge clk);
        check(temp_word == 12'h000 && !conv_done, "R1 zero until first result", temp_word, 0);
        @(negedge clk);
        check(conv_done == 1'b1, "R1 first result timing", conv_done, 1);
        check(temp_word == exp_val(12'h19D, 0), "R3 9-bit mask", temp_word, exp_val(12'h19D, 0));
        cur = 0;

        // R4 / R6: full resolution, signed values
        adc_sample = 12'h190;
        write_cfg(mk(0, 3, 0));
        wait_done(n);
        check(n == dur(0) - 1, "R5 old resolution in flight", n, dur(0) - 1);
        wait_done(n);
        check(n == dur(3), "R2 12-bit duration", n, dur(3));
        check(temp_word == 12'h190, "R4 +25C", temp_word, 12'h190);
        adc_sample = 12'hE70;
        wait_done(n);
        check(n == dur(3), "R6 back to back", n, dur(3));
        check(temp_word == 12'hE70, "R4 -25C", temp_word, 12'hE70);
        cur = 3;

        // R9 / R10: one-shot in continuous mode, spare bits
        write_cfg(8'hF4);
        check(cfg_rdata == 8'h74, "R10 readback os zero", cfg_rdata, 8'h74);
        wait_done(n);
        check(n == dur(3) - 1, "R9 no restart in continuous", n, dur(3) - 1);
        wait_done(n);
        check(n == dur(3), "R9 period unchanged", n, dur(3));

        // R2 / R3 / R5: random resolutions and samples
        for (int k = 0; k < 16; k++) begin
            r = int'($urandom % 4);
            s = 12'($urandom % 4096);
            adc_sample = s;
            write_cfg(mk(0, r, 0));
            wait_done(n);
            check(n == dur(cur) - 1, "R5 change waits for next start", n, dur(cur) - 1);
            check(temp_word == exp_val(s, cur), "R3 mask in flight", temp_word, exp_val(s, cur));
            wait_done(n);
            check(n == dur(r), "R2 duration per code", n, dur(r));
            check(temp_word == exp_val(s, r), "R3 mask per code", temp_word, exp_val(s, r));
            cur = r;
        end

        // R7: shutdown after current conversion
        adc_sample = 12'h2A5;
        write_cfg(mk(0, cur, 1));
        wait_done(n);
        check(n == dur(cur) - 1, "R7 in-flight completes", n, dur(cur) - 1);
        check(temp_word == exp_val(12'h2A5, cur), "R7 last value", temp_word, exp_val(12'h2A5, cur));
        held = temp_word;
        adc_sample = 12'h111;
        quiet(200, hits);
        check(hits == 0, "R7 no conversions when shut down", hits, 0);
        check(temp_word == held, "R7 result held", temp_word, held);

        // R8: one-shot while shut down
        adc_sample = 12'h333;
        write_cfg(mk(1, 1, 1));
        check(cfg_rdata == 8'h21, "R10 os reads zero", cfg_rdata, 8'h21);
        wait_done(n);
        check(n == dur(1), "R8 one-shot timing", n, dur(1));
        check(temp_word == exp_val(12'h333, 1), "R8 one-shot value", temp_word, exp_val(12'h333, 1));
        quiet(200, hits);
        check(hits == 0, "R8 single conversion", hits, 0);

        // R12: resume continuous
        write_cfg(mk(0, 0, 0));
        wait_done(n);
        check(n == dur(0) + 1, "R12 resume timing", n, dur(0) + 1);

        // R9: one-shot while shutdown is pending
        write_cfg(mk(1, 0, 1));
        wait_done(n);
        check(n == dur(0) - 1, "R9 pending no restart", n, dur(0) - 1);
        quiet(200, hits);
        check(hits == 0, "R9 no extra conversion", hits, 0);

        // R8 / R11: 12-bit one-shot, strobe width
        adc_sample = 12'h800;
        write_cfg(mk(1, 3, 1));
        wait_done(n);
        check(n == dur(3), "R8 12-bit one-shot timing", n, dur(3));
        check(temp_word == 12'h800, "R8 most negative", temp_word, 12'h800);
        adc_sample = 12'h0F0;
        @(negedge clk);
        check(!conv_done, "R11 strobe one cycle", conv_done, 0);
        check(temp_word == 12'h800, "R11 value stable", temp_word, 12'h800);
        quiet(300, hits);
        check(hits == 0, "R8 back to shutdown", hits, 0);

        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule